// File: doc/BRIEF.md
# Capture-Cycle Scan Group Clock Gate

This block sits between the tester's test clock and a full-scan design whose flops are split into several exclusive scan groups. It drives one clock per group. During shifting, every group gets every edge of the test clock. During the single capture cycle of each test vector, a control word picks which groups receive the capture edge. A group that is left out keeps its state, so the logic it feeds does not toggle and the capture-time switching current drops. Flops outside every group use a separate output that is never gated.

A pattern counter counts applied vectors. It advances when scan enable falls, which marks the move from shift to capture. The count is looked up in a table of ascending cluster boundaries. Each vector cluster owns one control word, set by parameter. Indices past the last boundary use an all-ones word, so late vectors are never gated. The tester drives scan enable and gate enable, and they must be settled while the test clock is low. Each group clock goes through a latch-based gate, and that latch takes its enable only during the low phase.

Top module: `capture_group_clkgate`

## Requirements
- R1: While `gate_en` is 0, every bit of `grp_clk` follows `clk_tst`: one rising edge per test clock rising edge, in shift, idle and reset alike.
- R2: While `gate_en` is 1, `grp_clk[g]` produces the test clock edge only if bit g of the selected control word is 1, and stays low if that bit is 0. Each vector gets exactly one such capture edge, and no cycle is added.
- R3: `free_clk` carries every test clock edge at all times, independent of `scan_en` and `gate_en`.
- R4: The vector index starts at 0 and goes up by one at a rising test clock edge where `scan_en` was 1 at the previous edge and is 0 at this one. It holds at every other edge and saturates at its maximum. The capture cycle of the k-th vector after reset therefore uses index k.
- R5: Cluster c covers the indices that are at least boundary c-1 (0 for c=0) and below boundary c. Boundary c sits at bits `[c*CNT_W +: CNT_W]` of `BOUNDS`, and its word sits at bits `[c*NGRP +: NGRP]` of `WORDS`. With the defaults, the boundaries are 3, 5, 8 and 10 and the words are 0101, 0010, 1000 and 0000 (binary, bit 0 on the right).
- R6: An index at or above the last boundary selects the all-ones word.
- R7: A gated clock is low whenever `clk_tst` is low. When enabled, it is high for the whole high phase of that cycle, because the enable is sampled only while the test clock is low.
- R8: An active-low `rst_n` clears the vector index at once, and the next vector captures with the word for index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tst | input | 1 | Test clock from the tester |
| rst_n | input | 1 | Asynchronous active-low reset of the pattern counter |
| scan_en | input | 1 | 1 = shift, 0 = capture or idle |
| gate_en | input | 1 | 1 = apply the control word in this cycle |
| grp_clk | output | NGRP | One clock per scan group |
| free_clk | output | 1 | Ungated clock for flops outside every group |

## Verification
The bench walks vectors through every cluster and past the last boundary, with shift lengths of one to three cycles. It counts the edges on each group clock and compares them with the word expected for that index. An off-by-one counter would show up at the cluster edges (indices 2/3, 4/5, 7/8 and 9/10) as the wrong group skipping its capture edge. A boundary compare that used less-or-equal would shift one vector into the next cluster. A missing all-ones default would leave groups unclocked after index 10. A reset in the middle of the run must bring the word back to cluster 0, and a counter that survives reset would show the wrong mask. During the capture cycle, the bench samples the gated clocks in the middle of the high phase and in the middle of the low phase, which catches a gate that clips the pulse or lets it through while the clock is low.

// File: rtl/scg_pkg.sv
package scg_pkg;
  typedef enum logic {PH_SHIFT = 1'b0, PH_CAPTURE = 1'b1} cap_phase_e;
endpackage

// File: rtl/scg_pattern_counter.sv
module scg_pattern_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  output logic [CNT_W-1:0] vec_idx
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic se_q;
  logic shift_end;

  // shift-to-capture transition: SE high last edge, low now
  assign shift_end = se_q && !scan_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se_q    <= 1'b0;
      vec_idx <= '0;
    end else begin
      se_q <= scan_en;
      if (shift_end && vec_idx != CNT_MAX) vec_idx <= vec_idx + 1'b1;
    end
  end
endmodule

// File: rtl/scg_cluster_map.sv
module scg_cluster_map #(
  parameter int                    NGRP   = 4,
  parameter int                    NCLU   = 4,
  parameter int                    CNT_W  = 8,
  parameter logic [NCLU*CNT_W-1:0] BOUNDS = '0,
  parameter logic [NCLU*NGRP-1:0]  WORDS  = '0
) (
  input  logic [CNT_W-1:0] vec_idx,
  output logic [NGRP-1:0]  ctl_word
);
  // Scan clusters from the highest down so the lowest match wins.
  always_comb begin
    ctl_word = '1;
    for (int c = NCLU - 1; c >= 0; c--) begin
      if (vec_idx < BOUNDS[c*CNT_W +: CNT_W]) ctl_word = WORDS[c*NGRP +: NGRP];
    end
  end
endmodule

// File: rtl/scg_clk_gate.sv
module scg_clk_gate (
  input  logic clk,
  input  logic en,
  output logic en_held,
  output logic gclk
);
  // transparent while clk is low; closed through the high phase
  always_latch begin
    if (!clk) en_held = en;
  end

  assign gclk = clk & en_held;
endmodule

// File: rtl/capture_group_clkgate.sv
module capture_group_clkgate
  import scg_pkg::*;
#(
  parameter int                    NGRP   = 4,
  parameter int                    NCLU   = 4,
  parameter int                    CNT_W  = 8,
  parameter logic [NCLU*CNT_W-1:0] BOUNDS = {8'd10, 8'd8, 8'd5, 8'd3},
  parameter logic [NCLU*NGRP-1:0]  WORDS  = {4'b0000, 4'b1000, 4'b0010, 4'b0101}
) (
  input  logic            clk_tst,
  input  logic            rst_n,
  input  logic            scan_en,
  input  logic            gate_en,
  output logic [NGRP-1:0] grp_clk,
  output logic            free_clk
);
  logic [CNT_W-1:0] vec_idx;
  logic [NGRP-1:0]  ctl_word;
  logic [NGRP-1:0]  grp_en;
  logic [NGRP-1:0]  grp_held;
  cap_phase_e       phase;

  scg_pattern_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk_tst),
    .rst_n   (rst_n),
    .scan_en (scan_en),
    .vec_idx (vec_idx)
  );

  scg_cluster_map #(
    .NGRP(NGRP), .NCLU(NCLU), .CNT_W(CNT_W), .BOUNDS(BOUNDS), .WORDS(WORDS)
  ) u_map (
    .vec_idx  (vec_idx),
    .ctl_word (ctl_word)
  );

  assign phase = gate_en ? PH_CAPTURE : PH_SHIFT;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_en[g] = (phase == PH_SHIFT) || ctl_word[g];
    scg_clk_gate u_gate (
      .clk     (clk_tst),
      .en      (grp_en[g]),
      .en_held (grp_held[g]),
      .gclk    (grp_clk[g])
    );
  end

  assign free_clk = clk_tst;
endmodule

// File: rtl/scg_checker.sv
module scg_checker #(
  parameter int                    NGRP   = 4,
  parameter int                    NCLU   = 4,
  parameter int                    CNT_W  = 8,
  parameter logic [NCLU*CNT_W-1:0] BOUNDS = '0
) (
  input logic             clk_tst,
  input logic             rst_n,
  input logic             scan_en,
  input logic             gate_en,
  input logic [CNT_W-1:0] vec_idx,
  input logic [NGRP-1:0]  ctl_word,
  input logic [NGRP-1:0]  grp_held
);
  localparam logic [CNT_W-1:0] LAST_BOUND = BOUNDS[(NCLU-1)*CNT_W +: CNT_W];

  assert_shift_all_R1: assert property (@(posedge clk_tst) disable iff (!rst_n)
    !gate_en |-> (&grp_held));

  assert_capture_word_R2: assert property (@(posedge clk_tst) disable iff (!rst_n)
    gate_en |-> (grp_held == ctl_word));

  assert_count_hold_R4: assert property (@(posedge clk_tst) disable iff (!rst_n)
    scan_en |=> $stable(vec_idx));

  assert_count_step_R4: assert property (@(posedge clk_tst) disable iff (!rst_n)
    1'b1 |=> ((vec_idx - $past(vec_idx)) <= 1));

  assert_count_sat_R4: assert property (@(posedge clk_tst) disable iff (!rst_n)
    (&vec_idx) |=> (&vec_idx));

  assert_tail_word_R6: assert property (@(posedge clk_tst) disable iff (!rst_n)
    (vec_idx >= LAST_BOUND) |-> (&ctl_word));
endmodule

bind capture_group_clkgate scg_checker #(
  .NGRP(NGRP), .NCLU(NCLU), .CNT_W(CNT_W), .BOUNDS(BOUNDS)
) u_chk (
  .clk_tst  (clk_tst),
  .rst_n    (rst_n),
  .scan_en  (scan_en),
  .gate_en  (gate_en),
  .vec_idx  (vec_idx),
  .ctl_word (ctl_word),
  .grp_held (grp_held)
);

// File: tb/test_capture_group_clkgate.sv
module test_capture_group_clkgate;
  localparam int NG = 4;

  logic          clk_tst = 1'b0;
  logic          rst_n   = 1'b0;
  logic          scan_en = 1'b0;
  logic          gate_en = 1'b0;
  logic [NG-1:0] grp_clk;
  logic          free_clk;

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct {
    int            base;
    logic [NG-1:0] cap;
    int            free;
    string         req;
  } exp_t;
  exp_t q[$];

  always #5 clk_tst = ~clk_tst;

  capture_group_clkgate #(
    .NGRP(NG), .NCLU(4), .CNT_W(8),
    .BOUNDS({8'd10, 8'd8, 8'd5, 8'd3}),
    .WORDS({4'b0000, 4'b1000, 4'b0010, 4'b0101})
  ) i_capture_group_clkgate (
    .clk_tst (clk_tst),
    .rst_n   (rst_n),
    .scan_en (scan_en),
    .gate_en (gate_en),
    .grp_clk (grp_clk),
    .free_clk(free_clk)
  );

  int edges [NG];
  int free_edges = 0;
  for (genvar g = 0; g < NG; g++) begin : g_mon
    int n = 0;
    always @(posedge grp_clk[g]) n = n + 1;
    assign edges[g] = n;
  end
  always @(posedge free_clk) free_edges = free_edges + 1;

  // R5/R6: expected word from the requirement's boundaries and words
  function automatic logic [NG-1:0] word_for(int idx);
    if (idx < 3)       return 4'b0101;
    else if (idx < 5)  return 4'b0010;
    else if (idx < 8)  return 4'b1000;
    else if (idx < 10) return 4'b0000;
    else               return 4'b1111;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: one vector, entered in the low phase
  task automatic run_vec(int idx, int len, string req);
    logic [NG-1:0] m;
    exp_t e;
    m = word_for(idx);
    scan_en = 1'b1; gate_en = 1'b0;
    repeat (len) @(negedge clk_tst);
    scan_en = 1'b0; gate_en = 1'b1;
    @(posedge clk_tst); #2;
    check({req, " R7 high-phase pulse"}, int'(grp_clk), int'(m));
    @(negedge clk_tst); #1;
    check("R7 low while clock low", int'(grp_clk), 0);
    gate_en = 1'b0;
    e.base = len; e.cap = m; e.free = len + 1; e.req = req;
    q.push_back(e);
  endtask

  task automatic do_reset(string req);
    exp_t e;
    rst_n = 1'b0; scan_en = 1'b0; gate_en = 1'b0;
    repeat (3) @(negedge clk_tst);
    #1 rst_n = 1'b1;
    e.base = 3; e.cap = '0; e.free = 3; e.req = req;
    q.push_back(e);
  endtask

  // monitor / scoreboard
  initial begin
    int snap [NG];
    int fsnap;
    exp_t e;
    for (int g = 0; g < NG; g++) snap[g] = 0;
    fsnap = 0;
    forever begin
      wait (q.size() > 0);
      e = q.pop_front();
      for (int g = 0; g < NG; g++) begin
        check($sformatf("%s grp%0d edges", e.req, g),
              edges[g] - snap[g], e.base + int'(e.cap[g]));
        snap[g] = edges[g];
      end
      check("R3 free clock edges", free_edges - fsnap, e.free);
      fsnap = free_edges;
    end
  end

  initial begin
    do_reset("R1/R8 reset state all clocked");
    for (int v = 0; v < 12; v++) begin
      string r;
      r = (v >= 10) ? "R6 tail all-ones" : "R2/R4/R5 cluster word";
      run_vec(v, 1 + (v % 3), r);
    end
    do_reset("R1 mid-run reset");
    run_vec(0, 2, "R8 index cleared by reset");
    run_vec(1, 3, "R8 second vector after reset");
    #20;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule